// File: doc/BRIEF.md
# Floating-Point Register Stack

This block holds the operand registers of a floating-point unit as a circular stack of eight 80-bit entries. A 3-bit pointer selects the physical slot that is the current top. Every other entry is named by its distance from that top: ST(i) is the entry i places below the top. Instructions see the stack only through two read ports. One always shows the top. The other shows ST(i) for the offset on `op_idx`. So every two-operand access has the top as one of its operands.

Each cycle the block accepts one operation code. Push loads a new value above the current top. Pop discards the top. Read checks that both operands are present. A result can be written back either to the top or to ST(i). Exchange swaps the top with ST(i). Every slot carries a valid tag. An operation that would overwrite a live entry raises an overflow pulse and does nothing else. An operation that needs an empty entry raises an underflow pulse and does nothing else.

The pulses come from a small three-state flag machine: `FLG_CLEAR`, `FLG_OVF` and `FLG_UNF`. Each cycle its next state follows the outcome of the operation the control logic decoded:
- a rejected push moves it to `FLG_OVF`;
- a rejected pop, read, write or exchange moves it to `FLG_UNF`;
- anything else returns it to `FLG_CLEAR`.

Top module: `fp_reg_stack`

## Requirements
- R1: While reset is active and on the first cycle after it, `top_ptr` is 0, `tag_vec` is all zeros, and both `ovf_flag` and `unf_flag` are low.
- R2: `rd_sti` shows the data of physical slot (`top_ptr` + `op_idx`) mod 8, and `sti_valid` shows that slot's tag. `rd_top` and `top_valid` show slot `top_ptr`.
- R3: Push (code 1) into an empty slot does three things at the clock edge: `top_ptr` becomes (`top_ptr` − 1) mod 8 (so 0 wraps to 7), `wr_data` is stored in the new top slot, and the tag of that slot is set.
- R4: Push into a slot whose tag is already set raises `ovf_flag` and changes neither the pointer, the tags nor any data.
- R5: Pop (code 2) of a valid top clears the tag of the top slot, and `top_ptr` becomes (`top_ptr` + 1) mod 8.
- R6: Pop of an empty top, or Read (code 3) when the top or ST(i) is empty, raises `unf_flag` and leaves all state unchanged. A Read with both operands valid changes nothing and raises no flag.
- R7: Write-top (code 4) replaces the data of a valid top with `wr_data`. If the top is empty, it raises `unf_flag` instead and changes nothing.
- R8: Write-ST(i) (code 5) stores `wr_data` into ST(i) and sets its tag, provided the top is valid. If the top is empty, it raises `unf_flag` and changes nothing.
- R9: Exchange (code 6) swaps the data of the top and ST(i) when both are valid. If either is empty, it raises `unf_flag` and changes nothing.
- R10: The flags are registered one-cycle pulses. They describe only the operation accepted at the previous clock edge, and at most one of them is high. No-op (code 0) and code 7 change no state and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | 0 no-op, 1 push, 2 pop, 3 read, 4 write top, 5 write ST(i), 6 exchange, 7 no-op |
| op_idx | input | 3 | Offset i of the second operand ST(i) from the top |
| wr_data | input | 80 | Value for push and for the two write-back operations |
| rd_top | output | 80 | Data of the top entry |
| rd_sti | output | 80 | Data of entry ST(op_idx) |
| top_valid | output | 1 | Tag of the top entry |
| sti_valid | output | 1 | Tag of entry ST(op_idx) |
| top_ptr | output | 3 | Physical slot number of the current top |
| tag_vec | output | 8 | Tags of all physical slots, bit n for slot n |
| ovf_flag | output | 1 | Overflow pulse for the previous operation |
| unf_flag | output | 1 | Underflow pulse for the previous operation |

## Verification
The bench builds the block with its default sizes: eight entries of 80 bits. With eight entries, the pointer wraps from 0 to 7 on the very first push, a ninth push reaches the overflow case, and eight pops empty the stack again. The wide data lets random 80-bit words show any lost or misrouted upper bits during exchanges. A long random stream of operations then mixes offsets and codes, so that every offset appears with both full and empty slots.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_READ  = 3'd3,
        OP_WRTOP = 3'd4,
        OP_WRSTI = 3'd5,
        OP_XCHG  = 3'd6,
        OP_RSVD  = 3'd7
    } fpstk_op_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_DONE,
        RES_OVF,
        RES_UNF
    } fpstk_res_e;

    typedef enum logic [1:0] {
        FLG_CLEAR,
        FLG_OVF,
        FLG_UNF
    } fpstk_flg_e;

endpackage

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fpstk_op_e        op,
    input  logic [PTR_W-1:0] idx,
    input  logic [DEPTH-1:0] tag_vec,
    output logic [PTR_W-1:0] top_q,
    output logic [PTR_W-1:0] slot_sti,
    output fpstk_res_e       res,
    output logic             wa_en,
    output logic [PTR_W-1:0] wa_idx,
    output logic             wa_swap,
    output logic             wb_en,
    output logic [PTR_W-1:0] wb_idx,
    output logic             clr_en,
    output logic [PTR_W-1:0] clr_idx
);

    logic [PTR_W-1:0] top_d;
    logic [PTR_W-1:0] slot_new;
    logic             top_ok;
    logic             sti_ok;

    // Slot numbers wrap modulo DEPTH through the natural width of the pointer.
    assign slot_sti = top_q + idx;
    assign slot_new = top_q - PTR_W'(1);
    assign top_ok   = tag_vec[top_q];
    assign sti_ok   = tag_vec[slot_sti];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        top_d   = top_q;
        res     = RES_NONE;
        wa_en   = 1'b0;
        wa_idx  = top_q;
        wa_swap = 1'b0;
        wb_en   = 1'b0;
        wb_idx  = slot_sti;
        clr_en  = 1'b0;
        clr_idx = top_q;
        unique case (op)
            OP_PUSH: begin
                if (tag_vec[slot_new]) begin
                    res = RES_OVF;
                end else begin
                    res    = RES_DONE;
                    wa_en  = 1'b1;
                    wa_idx = slot_new;
                    top_d  = slot_new;
                end
            end
            OP_POP: begin
                if (!top_ok) begin
                    res = RES_UNF;
                end else begin
                    res    = RES_DONE;
                    clr_en = 1'b1;
                    top_d  = top_q + PTR_W'(1);
                end
            end
            OP_READ: begin
                res = (top_ok && sti_ok) ? RES_DONE : RES_UNF;
            end
            OP_WRTOP: begin
                if (!top_ok) begin
                    res = RES_UNF;
                end else begin
                    res   = RES_DONE;
                    wa_en = 1'b1;
                end
            end
            OP_WRSTI: begin
                if (!top_ok) begin
                    res = RES_UNF;
                end else begin
                    res    = RES_DONE;
                    wa_en  = 1'b1;
                    wa_idx = slot_sti;
                end
            end
            OP_XCHG: begin
                if (!(top_ok && sti_ok)) begin
                    res = RES_UNF;
                end else begin
                    res     = RES_DONE;
                    wa_en   = 1'b1;
                    wa_swap = 1'b1;
                    wb_en   = 1'b1;
                end
            end
            OP_NOP, OP_RSVD: begin
                res = RES_NONE;
            end
        endcase
    end

    // R5: a pop that removes an entry must clear the tag of the slot it leaves
    a_r5_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !tag_vec[$past(clr_idx)]);

    // R3: an accepted push must leave the written slot tagged as the new top
    a_r3_push_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && res == RES_DONE) |=> tag_vec[top_q]);

endmodule

// File: rtl/fpstk_bank.sv
module fpstk_bank #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wa_en,
    input  logic [PTR_W-1:0] wa_idx,
    input  logic [WIDTH-1:0] wa_data,
    input  logic             wb_en,
    input  logic [PTR_W-1:0] wb_idx,
    input  logic [WIDTH-1:0] wb_data,
    input  logic             clr_en,
    input  logic [PTR_W-1:0] clr_idx,
    input  logic [PTR_W-1:0] rd_a_idx,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [PTR_W-1:0] rd_b_idx,
    output logic [WIDTH-1:0] rd_b_data,
    output logic [DEPTH-1:0] tag_q
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic             tag_r;
        logic [WIDTH-1:0] data_r;
        logic             hit_a;
        logic             hit_b;
        logic             hit_c;

        assign hit_a = wa_en  && (wa_idx  == PTR_W'(g));
        assign hit_b = wb_en  && (wb_idx  == PTR_W'(g));
        assign hit_c = clr_en && (clr_idx == PTR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     tag_r <= 1'b0;
            else if (hit_a) tag_r <= 1'b1;
            else if (hit_c) tag_r <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (hit_a)      data_r <= wa_data;
            else if (hit_b) data_r <= wb_data;
        end

        assign tag_q[g]  = tag_r;
        assign slot_q[g] = data_r;
    end

    assign rd_a_data = slot_q[rd_a_idx];
    assign rd_b_data = slot_q[rd_b_idx];

endmodule

// File: rtl/fpstk_flags.sv
module fpstk_flags
    import fpstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fpstk_res_e res,
    output logic       ovf_flag,
    output logic       unf_flag
);

    fpstk_flg_e flg_q;
    fpstk_flg_e flg_d;

    always_comb begin
        unique case (res)
            RES_OVF:           flg_d = FLG_OVF;
            RES_UNF:           flg_d = FLG_UNF;
            RES_NONE, RES_DONE: flg_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= FLG_CLEAR;
        else        flg_q <= flg_d;
    end

    always_comb begin
        ovf_flag = 1'b0;
        unf_flag = 1'b0;
        unique case (flg_q)
            FLG_CLEAR: ;
            FLG_OVF:   ovf_flag = 1'b1;
            FLG_UNF:   unf_flag = 1'b1;
            default:   ;
        endcase
    end

    // R10: an operation that completed normally leaves both flags low in the next cycle
    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (res == RES_DONE || res == RES_NONE) |=> (!ovf_flag && !unf_flag));

endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_code,
    input  logic [PTR_W-1:0] op_idx,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_top,
    output logic [WIDTH-1:0] rd_sti,
    output logic             top_valid,
    output logic             sti_valid,
    output logic [PTR_W-1:0] top_ptr,
    output logic [DEPTH-1:0] tag_vec,
    output logic             ovf_flag,
    output logic             unf_flag
);

    fpstk_op_e        op;
    fpstk_res_e       res;
    logic [PTR_W-1:0] slot_sti;
    logic             wa_en;
    logic [PTR_W-1:0] wa_idx;
    logic             wa_swap;
    logic             wb_en;
    logic [PTR_W-1:0] wb_idx;
    logic             clr_en;
    logic [PTR_W-1:0] clr_idx;
    logic [WIDTH-1:0] wa_data;

    assign op      = fpstk_op_e'(op_code);
    assign wa_data = wa_swap ? rd_sti : wr_data;

    fpstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .idx      (op_idx),
        .tag_vec  (tag_vec),
        .top_q    (top_ptr),
        .slot_sti (slot_sti),
        .res      (res),
        .wa_en    (wa_en),
        .wa_idx   (wa_idx),
        .wa_swap  (wa_swap),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx)
    );

    fpstk_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wa_en     (wa_en),
        .wa_idx    (wa_idx),
        .wa_data   (wa_data),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (rd_top),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .rd_a_idx  (top_ptr),
        .rd_a_data (rd_top),
        .rd_b_idx  (slot_sti),
        .rd_b_data (rd_sti),
        .tag_q     (tag_vec)
    );

    fpstk_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .res      (res),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    assign top_valid = tag_vec[top_ptr];
    assign sti_valid = tag_vec[slot_sti];

    // Slot just above the top, recomputed here only for the checks below.
    logic [PTR_W-1:0] chk_above;
    assign chk_above = top_ptr - PTR_W'(1);

    // R3: an accepted push moves the pointer down by one
    a_r3_push_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && !tag_vec[chk_above]) |=> top_ptr == $past(chk_above));

    // R4: push onto an occupied slot flags overflow and freezes pointer and tags
    a_r4_no_overflow_change: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && tag_vec[chk_above]) |=>
            (ovf_flag && $stable(top_ptr) && $stable(tag_vec)));

    // R5: an accepted pop moves the pointer up by one
    a_r5_pop_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && top_valid) |=> top_ptr == $past(top_ptr) + PTR_W'(1));

    // R6: pop of an empty top flags underflow and changes nothing
    a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && !top_valid) |=>
            (unf_flag && $stable(top_ptr) && $stable(tag_vec)));

    // R9: exchange with a missing operand flags underflow
    a_r9_xchg_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_XCHG && !(top_valid && sti_valid)) |=> unf_flag);

    // R10: at most one flag is raised
    a_r10_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

endmodule

// File: tb/fp_reg_stack_bench.sv
module fp_reg_stack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int W          = 80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_code = 3'd0;
    logic [2:0]   op_idx = 3'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_top, rd_sti;
    logic         top_valid, sti_valid;
    logic [2:0]   top_ptr;
    logic [N-1:0] tag_vec;
    logic         ovf_flag, unf_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    logic [W-1:0] m_data [N];
    bit           m_tag  [N];
    int           m_top;
    bit           m_ovf, m_unf;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_reg_stack u_fp_reg_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .op_idx    (op_idx),
        .wr_data   (wr_data),
        .rd_top    (rd_top),
        .rd_sti    (rd_sti),
        .top_valid (top_valid),
        .sti_valid (sti_valid),
        .top_ptr   (top_ptr),
        .tag_vec   (tag_vec),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd80();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    // Apply the requirements to the reference state for one accepted operation.
    task automatic model_step(int op, int idx, logic [W-1:0] d);
        int t = m_top;
        int s = (m_top + idx) % N;
        int n = (m_top + N - 1) % N;
        logic [W-1:0] tmp;
        m_ovf = 0;
        m_unf = 0;
        case (op)
            1: if (m_tag[n]) m_ovf = 1;                          // R3, R4
               else begin m_top = n; m_data[n] = d; m_tag[n] = 1; end
            2: if (!m_tag[t]) m_unf = 1;                         // R5, R6
               else begin m_tag[t] = 0; m_top = (t + 1) % N; end
            3: if (!m_tag[t] || !m_tag[s]) m_unf = 1;            // R6
            4: if (!m_tag[t]) m_unf = 1; else m_data[t] = d;     // R7
            5: if (!m_tag[t]) m_unf = 1;                         // R8
               else begin m_data[s] = d; m_tag[s] = 1; end
            6: if (!m_tag[t] || !m_tag[s]) m_unf = 1;            // R9
               else begin tmp = m_data[t]; m_data[t] = m_data[s]; m_data[s] = tmp; end
            default: ;                                           // R10
        endcase
    endtask

    task automatic compare_all(int idx);
        logic [N-1:0] etags;
        int s = (m_top + idx) % N;
        for (int k = 0; k < N; k++) etags[k] = m_tag[k];
        chk("R3 R5", "top_ptr", W'(top_ptr), W'(m_top));
        chk("R5 R8", "tag_vec", W'(tag_vec), W'(etags));
        chk("R4 R10", "ovf_flag", W'(ovf_flag), W'(m_ovf));
        chk("R6 R10", "unf_flag", W'(unf_flag), W'(m_unf));
        chk("R2", "top_valid", W'(top_valid), W'(m_tag[m_top]));
        chk("R2", "sti_valid", W'(sti_valid), W'(m_tag[s]));
        if (m_tag[m_top]) chk("R7 R9", "rd_top", rd_top, m_data[m_top]);
        if (m_tag[s])     chk("R2 R9", "rd_sti", rd_sti, m_data[s]);
    endtask

    task automatic do_op(int op, int idx, logic [W-1:0] d);
        op_code = 3'(op);
        op_idx  = 3'(idx);
        wr_data = d;
        @(posedge clk);
        model_step(op, idx, d);
        @(negedge clk);
        compare_all(idx);
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin m_tag[k] = 0; m_data[k] = '0; end
        m_top = 0; m_ovf = 0; m_unf = 0;
        repeat (3) @(posedge clk);
        // R1: reset values while reset is held
        @(negedge clk);
        chk("R1", "reset top_ptr", W'(top_ptr), '0);
        chk("R1", "reset tag_vec", W'(tag_vec), '0);
        chk("R1", "reset flags", W'({ovf_flag, unf_flag}), '0);
        rst_n = 1'b1;
        do_op(0, 0, '0);                                  // R1, R10: first cycle idle

        do_op(2, 0, '0);                                  // R6: pop of empty stack
        do_op(3, 0, '0);                                  // R6: read of empty stack
        do_op(4, 0, rnd80());                             // R7: write to empty top
        do_op(5, 2, rnd80());                             // R8: write ST(i) with empty top
        do_op(1, 0, rnd80());                             // R3: push wraps 0 to 7
        do_op(7, 3, rnd80());                             // R10: code 7 idle
        for (int k = 0; k < 7; k++) do_op(1, k, rnd80()); // R3: fill the stack
        do_op(1, 0, rnd80());                             // R4: overflow on full stack
        for (int i = 0; i < N; i++) do_op(3, i, '0);      // R2, R6: read every offset
        do_op(6, 3, '0);                                  // R9: exchange
        do_op(6, 0, '0);                                  // R9: exchange with itself
        do_op(4, 0, rnd80());                             // R7
        do_op(5, 5, rnd80());                             // R8
        for (int k = 0; k < 5; k++) do_op(2, 0, '0);      // R5
        do_op(6, 6, '0);                                  // R9: second operand empty
        do_op(5, 6, rnd80());                             // R8: fills empty ST(i)
        do_op(3, 7, '0);                                  // R6: other operand empty
        for (int k = 0; k < 4; k++) do_op(2, 0, '0);      // R5, R6
        for (int k = 0; k < 1500; k++) begin
            int op = (($urandom() % 4) == 0) ? 1 : int'($urandom() % 8);
            do_op(op, int'($urandom() % 8), rnd80());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule